// File: doc/BRIEF.md
# Prioritized Processor Interrupt Level Selector

This block sits next to a processor core and decides which interrupt level, if any, should be signalled to it. It merges fifteen external level-sensitive request lines with a software interrupt register into one pending vector of sixteen levels. It then picks the highest pending level that outranks the core's current interrupt priority, and offers it as a request together with a trap-type code. Two timer-match flags in the software register do not map onto their own bit positions. Either one of them raises level 14.

A small two-state machine holds the request. In QUIET no request is offered and the stored trap type is zero. In ASSERT the request is high and the stored trap type names the level being offered. The machine has these transitions:
- RAISE (QUIET to ASSERT): a qualifying level is found.
- RETARGET (ASSERT to ASSERT): the stored trap type is replaced by a different qualifying one.
- DRAIN (ASSERT to QUIET): the pending vector becomes empty.

The core can hold off a new request in two ways. It can clear the global enable, which freezes the state. It can also be handling a trap of a higher type at a nonzero trap level, which blocks the request. A separate wake output pulses whenever an external line rises, so that a halted core can resume.

Top module: `irq_level_sel`

## Requirements
- R1: The pending vector is the bitwise OR of the external lines (`ext_irq[i]` drives level i, i = 1..15) and software register bits 1..15 (`soft_int[i]` drives level i). Level 0 never produces a request, and `soft_int[0]` does not act as a level.
- R2: `soft_int[0]` (tick match) and `soft_int[16]` (system-tick match) each force level 14 pending, and neither sets any other level.
- R3: When the pending vector is empty and the request is high, the next clock drops the request and returns the trap-type output to 0, whatever the enable.
- R4: With enable high, the chosen level is the highest pending level strictly greater than `cur_pil`. Pending levels at or below `cur_pil` are never chosen.
- R5: The trap type for level i is 0x40 OR i, giving 0x41..0x4F on the 9-bit `irq_tt` output.
- R6: When `trap_lvl` is nonzero and `cur_tt` is greater than the candidate trap type, the request and the trap type are left unchanged.
- R7: A candidate that differs from the stored trap type is stored and the request is driven high. A candidate equal to the stored value changes nothing.
- R8: With enable low and the pending vector nonempty, the request and the trap type hold their values.
- R9: `wake` is high for exactly one cycle after a clock edge at which any external line was sampled high having been low at the edge before.
- R10: During and immediately after reset, `irq_req`, `irq_tt` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 15 | External level lines for levels 15..1 |
| soft_int | input | 17 | Software register; bit 0 tick match, bit 16 system-tick match |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type being handled at the current trap level |
| irq_req | output | 1 | Interrupt request to the core |
| irq_tt | output | 9 | Trap type of the offered request, 0 when idle |
| wake | output | 1 | One-cycle pulse on a rising external line |

## Verification
All three outputs are registered. A change in the inputs that is sampled at a clock edge shows up on `irq_req`, `irq_tt` and `wake` right after that same edge, so every result is due exactly one edge after its stimulus. The bench drives inputs just after a falling edge. A behavioural model steps on the rising edge from the same inputs, and the outputs are compared against it at the next falling edge, once per cycle. Each stimulus phase carries the tag of the requirement it exercises, so a mismatch is reported against that requirement.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_ASSERT = 1'b1
    } req_state_e;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
    parameter int NUM_LVL   = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [NUM_LVL-1:1] ext_irq,
    input  logic [NUM_LVL:0]   soft_int,
    output logic [NUM_LVL-1:0] pend
);
    logic timer_hit;
    assign timer_hit = soft_int[0] | soft_int[NUM_LVL];
    assign pend[0]   = 1'b0;

    for (genvar i = 1; i < NUM_LVL; i++) begin : g_lvl
        if (i == TIMER_LVL) begin : g_timer
            assign pend[i] = ext_irq[i] | soft_int[i] | timer_hit;
        end else begin : g_plain
            assign pend[i] = ext_irq[i] | soft_int[i];
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_LVL = 16,
    parameter int LVL_W   = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] pend,
    input  logic [LVL_W-1:0]   floor_lvl,
    output logic               found,
    output logic [LVL_W-1:0]   lvl
);
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (pend[i] && (LVL_W'(i) > floor_lvl)) begin
                found = 1'b1;
                lvl   = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
    parameter int NUM_LVL = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:1] ext_irq,
    output logic               wake
);
    logic [NUM_LVL-1:1] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            wake   <= 1'b0;
        end else begin
            prev_q <= ext_irq;
            wake   <= |(ext_irq & ~prev_q);
        end
    end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
    import irq_sel_pkg::*;
#(
    parameter int          NUM_LVL   = 16,
    parameter int          TIMER_LVL = 14,
    parameter int          TT_W      = 9,
    parameter int          TL_W      = 3,
    parameter logic [8:0]  TRAP_BASE = 9'h040
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LVL-1:1]         ext_irq,
    input  logic [NUM_LVL:0]           soft_int,
    input  logic [$clog2(NUM_LVL)-1:0] cur_pil,
    input  logic                       int_en,
    input  logic [TL_W-1:0]            trap_lvl,
    input  logic [TT_W-1:0]            cur_tt,
    output logic                       irq_req,
    output logic [TT_W-1:0]            irq_tt,
    output logic                       wake
);
    localparam int LVL_W = $clog2(NUM_LVL);

    logic [NUM_LVL-1:0] pend;
    logic               found;
    logic [LVL_W-1:0]   lvl;
    logic [TT_W-1:0]    cand_tt;
    logic               blocked;
    req_state_e         state_q, state_d;
    logic [TT_W-1:0]    tt_q, tt_d;

    irq_pend_merge #(.NUM_LVL(NUM_LVL), .TIMER_LVL(TIMER_LVL)) u_merge (
        .ext_irq (ext_irq),
        .soft_int(soft_int),
        .pend    (pend)
    );

    irq_prio_pick #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_pick (
        .pend     (pend),
        .floor_lvl(cur_pil),
        .found    (found),
        .lvl      (lvl)
    );

    irq_wake_det #(.NUM_LVL(NUM_LVL)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_irq(ext_irq),
        .wake   (wake)
    );

    assign cand_tt = TT_W'(TRAP_BASE) | TT_W'(lvl);
    assign blocked = (trap_lvl != '0) && (cur_tt > cand_tt);

    // Next-state logic: RAISE, RETARGET, DRAIN
    always_comb begin
        state_d = state_q;
        tt_d    = tt_q;
        unique case (state_q)
            ST_QUIET: begin
                if ((pend != '0) && int_en && found && !blocked && (cand_tt != tt_q)) begin
                    state_d = ST_ASSERT;
                    tt_d    = cand_tt;
                end
            end
            ST_ASSERT: begin
                if (pend == '0) begin
                    state_d = ST_QUIET;
                    tt_d    = '0;
                end else if (int_en && found && !blocked && (cand_tt != tt_q)) begin
                    tt_d    = cand_tt;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            tt_q    <= '0;
        end else begin
            state_q <= state_d;
            tt_q    <= tt_d;
        end
    end

    always_comb begin
        irq_req = (state_q == ST_ASSERT);
        irq_tt  = tt_q;
    end

    a_r3_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0 && irq_req) |=> (!irq_req && irq_tt == '0));

    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && pend != '0) |=> ($stable(irq_req) && $stable(irq_tt)));

    a_r6_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0 && blocked) |=> ($stable(irq_req) && $stable(irq_tt)));

    a_r5_tt_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_tt[TT_W-1:LVL_W] == TRAP_BASE[TT_W-1:LVL_W] && irq_tt[LVL_W-1:0] != '0));

    a_r4_chosen_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en && pend != '0 && found) |-> (lvl > cur_pil && pend[lvl]));
endmodule

// File: tb/tb_irq_level_sel.sv
module tb_irq_level_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] ext_irq = '0;
    logic [16:0] soft_int = '0;
    logic [3:0]  cur_pil = '0;
    logic        int_en = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  cur_tt = '0;
    logic        irq_req, wake;
    logic [8:0]  irq_tt;

    int    n_run = 0;
    int    n_fail = 0;
    string tag = "R10";
    bit    done = 1'b0;

    // reference model state
    bit          m_req = 0;
    int          m_tt = 0;
    bit          m_wake = 0;
    logic [15:1] m_prev = '0;

    irq_level_sel dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .soft_int(soft_int),
        .cur_pil(cur_pil), .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
        .irq_req(irq_req), .irq_tt(irq_tt), .wake(wake)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        int pv, best, cand;
        if (!rst_n) begin
            m_req <= 0; m_tt <= 0; m_wake <= 0; m_prev <= '0;
        end else begin
            pv = 0;
            for (int i = 1; i < 16; i++)
                if (ext_irq[i] || soft_int[i]) pv |= (1 << i);
            if (soft_int[0] || soft_int[16]) pv |= (1 << 14);
            m_wake <= ((ext_irq & ~m_prev) != 0);
            m_prev <= ext_irq;
            if (pv == 0) begin
                if (m_req) begin m_req <= 0; m_tt <= 0; end
            end else if (int_en) begin
                best = 0;
                for (int i = 15; i > int'(cur_pil); i--)
                    if (best == 0 && ((pv >> i) & 1)) best = i;
                if (best != 0) begin
                    cand = 64 + best;
                    if (!(trap_lvl != 0 && int'(cur_tt) > cand) && cand != m_tt) begin
                        m_tt <= cand; m_req <= 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_run++;
            if (irq_req !== m_req || int'(irq_tt) != m_tt || wake !== m_wake) begin
                n_fail++;
                $display("FAIL %s: got req=%0b tt=%h wake=%0b, expected req=%0b tt=%h wake=%0b",
                         tag, irq_req, irq_tt, wake, m_req, m_tt[8:0], m_wake);
            end
        end
    end

    task automatic hold(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    task automatic expect_out(string t, bit r, int tt);
        n_run++;
        if (irq_req !== r || int'(irq_tt) != tt) begin
            n_fail++;
            $display("FAIL %s: got req=%0b tt=%h, expected req=%0b tt=%h", t, irq_req, irq_tt, r, tt[8:0]);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        hold(3);
        n_run++;
        if (irq_req !== 0 || irq_tt !== 0 || wake !== 0) begin
            n_fail++;
            $display("FAIL R10: got req=%0b tt=%h wake=%0b, expected 0 0 0", irq_req, irq_tt, wake);
        end
        rst_n = 1; hold(2);
        expect_out("R10", 0, 0);

        // R1/R5/R9: one external line
        tag = "R1"; int_en = 1; ext_irq[5] = 1; hold(2);
        expect_out("R5", 1, 'h45);
        // R4/R7: higher line retargets
        tag = "R7"; ext_irq[9] = 1; hold(2);
        expect_out("R7", 1, 'h49);
        // R3: drain
        tag = "R3"; ext_irq = '0; hold(2);
        expect_out("R3", 0, 0);
        // R1: software levels, bit 0 alone is not a level
        tag = "R1"; soft_int[3] = 1; hold(2);
        expect_out("R1", 1, 'h43);
        soft_int = '0; hold(2);
        // R2: timer flags force level 14
        tag = "R2"; soft_int[0] = 1; hold(2);
        expect_out("R2", 1, 'h4E);
        soft_int = '0; hold(2);
        soft_int[16] = 1; hold(2);
        expect_out("R2", 1, 'h4E);
        soft_int = '0; hold(2);
        // R4: levels at or below pil ignored
        tag = "R4"; cur_pil = 9; ext_irq[9] = 1; ext_irq[4] = 1; hold(3);
        expect_out("R4", 0, 0);
        ext_irq[10] = 1; hold(2);
        expect_out("R4", 1, 'h4A);
        ext_irq = '0; cur_pil = 0; hold(2);
        // R8: disabled holds
        tag = "R8"; ext_irq[6] = 1; hold(2);
        int_en = 0; ext_irq[12] = 1; hold(3);
        expect_out("R8", 1, 'h46);
        int_en = 1; hold(2);
        expect_out("R8", 1, 'h4C);
        ext_irq = '0; hold(2);
        // R6: trap-level blocking
        tag = "R6"; trap_lvl = 1; cur_tt = 'h4C; ext_irq[11] = 1; hold(3);
        expect_out("R6", 0, 0);
        cur_tt = 'h4B; hold(2);
        expect_out("R6", 1, 'h4B);
        ext_irq = '0; hold(2);
        cur_tt = 'h1FF; trap_lvl = 0; ext_irq[2] = 1; hold(2);
        expect_out("R6", 1, 'h42);
        ext_irq = '0; hold(2);
        // R9: wake pulses on rising lines, repeated toggles
        tag = "R9";
        for (int k = 1; k < 15; k += 3) begin
            ext_irq[k] = 1; hold(1);
            n_run++;
            if (wake !== 1) begin n_fail++; $display("FAIL R9: got wake=%0b, expected 1", wake); end
            hold(1);
            n_run++;
            if (wake !== 0) begin n_fail++; $display("FAIL R9: got wake=%0b, expected 0", wake); end
            ext_irq[k] = 0;
        end
        hold(4);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule